// File: doc/BRIEF.md
# Pipelined Sorting Network

This block sorts a fixed-size tuple of unsigned keys into ascending order. The tuple arrives as one wide bus together with a valid strobe, and passes through a chain of compare-and-swap cells. A register sits between every group of cells, so a new tuple can enter on every clock. Each tuple leaves after a fixed number of cycles on a matching output bus with its own valid strobe. While that happens, one independent tuple sits in each stage.

Lane 0 occupies the least significant `KEY_W` bits of each bus, and lane k occupies bits `[k*KEY_W +: KEY_W]`. On output, lane 0 holds the smallest key.

The `LANES` parameter selects the network:
- **Four lanes (the default)** use five comparators in three stages. The stages compare lane pairs (0,1)(2,3), then (0,2)(1,3), then (1,2).
- **Eight lanes** use a regular odd-even transposition arrangement of eight stages. Even stages compare (0,1)(2,3)(4,5)(6,7). Odd stages compare (1,2)(3,4)(5,6).

Any other lane count is rejected when the design is elaborated. There is no backpressure: a downstream consumer must accept every valid output.

Top module: `sn_sort_pipe`

## Requirements
- R1: When `out_valid` is high, the output lanes are in ascending unsigned order: lane k is less than or equal to lane k+1 for every k.
- R2: Every output tuple is a permutation of the input tuple it came from, so the multiset of keys is unchanged.
- R3: A tuple sampled with `in_valid` high at rising edge n appears with `out_valid` high after rising edge n+L-1, where L is 3 for four lanes and 8 for eight lanes.
- R4: Tuples presented on consecutive cycles leave on consecutive cycles, in the order in which they entered, with no gaps.
- R5: While `rst_n` is low, `out_valid` is low, and tuples already in flight are discarded. After reset is released, no output appears until a new tuple has had time to travel the full latency.
- R6: A cycle with `in_valid` low produces a cycle with `out_valid` low exactly L cycles later, whatever value `in_data` had.
- R7: Equal keys are never swapped. Tuples that contain duplicate keys come out sorted, and each duplicated value appears as many times as it went in.
- R8: Comparisons are unsigned: a key with its most significant bit set sorts above every key with that bit clear.
- R9: With `LANES` set to 8, the odd-even transposition network sorts every tuple of eight keys, including all 256 tuples built only from the minimum and maximum key values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears every stage valid bit |
| in_valid | input | 1 | High when `in_data` carries a tuple to sort |
| in_data | input | LANES*KEY_W | Unsorted tuple; lane k is at bits [k*KEY_W +: KEY_W] |
| out_valid | output | 1 | High when `out_data` carries a sorted tuple |
| out_data | output | LANES*KEY_W | Sorted tuple; lane 0 holds the smallest key |

## Verification
The four-lane build is driven with every tuple drawn from five keys. These keys are zero, one, a small value, the most significant bit alone and all ones. The set therefore covers:
- duplicate keys, where a swap made on equality would still sort but a miswired cell would lose a value;
- keys that straddle the sign bit, where a signed compare would place the large keys first;
- every ordering of distinct keys, where a missing or misplaced comparator leaves some order unsorted.

The eight-lane build is given all 256 tuples made only of the minimum and maximum keys. A network that sorts all of these sorts every input, so a wrong stage schedule is caught. Pseudo-random tuples follow.

Bubbles with garbage data are mixed into the stream. A valid bit that does not travel with its data would emit a phantom tuple or drop a real one. A latency counted wrongly moves each result off its expected cycle.

A reset applied while the pipeline is full checks that no stale tuple leaks out afterwards.

// File: rtl/sn_pkg.sv
package sn_pkg;

   // Number of register stages for a supported lane count.
   function automatic int stage_count(int lanes);
      return (lanes == 4) ? 3 : lanes;
   endfunction

   // Lane compared with `lane` in stage `stg`; returns `lane` itself when
   // the lane is not touched in that stage.
   function automatic int partner(int lanes, int stg, int lane);
      if (lanes == 4) begin
         case (stg)
            0:       return lane ^ 1;
            1:       return lane ^ 2;
            default: return (lane == 1) ? 2 : ((lane == 2) ? 1 : lane);
         endcase
      end
      if ((stg % 2) == 0) return lane ^ 1;
      if ((lane == 0) || (lane == lanes - 1)) return lane;
      return ((lane % 2) == 1) ? lane + 1 : lane - 1;
   endfunction

endpackage

// File: rtl/sn_cas.sv
module sn_cas #(
   parameter int KEY_W = 16
) (
   input  logic [KEY_W-1:0] a_i,
   input  logic [KEY_W-1:0] b_i,
   output logic [KEY_W-1:0] lo_o,
   output logic [KEY_W-1:0] hi_o
);
   logic swap;

   // Swap only on strict greater-than, so equal keys keep their lanes.
   assign swap = (a_i > b_i);
   assign lo_o = swap ? b_i : a_i;
   assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/sn_stage.sv
module sn_stage #(
   parameter int LANES = 4,
   parameter int KEY_W = 16,
   parameter int STG   = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   v_i,
   input  logic [LANES*KEY_W-1:0] d_i,
   output logic                   v_o,
   output logic [LANES*KEY_W-1:0] d_o
);
   localparam int BUS_W = LANES * KEY_W;

   logic [KEY_W-1:0] lane_in  [LANES];
   logic [KEY_W-1:0] lane_net [LANES];
   logic [BUS_W-1:0] net_flat;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int P = sn_pkg::partner(LANES, STG, i);

      if ((P < 0) || (P >= LANES) || (sn_pkg::partner(LANES, STG, P) != i)) begin : g_bad
         $error("sn_stage: inconsistent comparator schedule at stage %0d lane %0d", STG, i);
      end

      assign lane_in[i] = d_i[i*KEY_W +: KEY_W];

      if (P > i) begin : g_cas
         sn_cas #(.KEY_W(KEY_W)) u_cas (
            .a_i  (lane_in[i]),
            .b_i  (lane_in[P]),
            .lo_o (lane_net[i]),
            .hi_o (lane_net[P])
         );
      end else if (P == i) begin : g_pass
         assign lane_net[i] = lane_in[i];
      end

      assign net_flat[i*KEY_W +: KEY_W] = lane_net[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o <= 1'b0;
         d_o <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) d_o <= net_flat;
      end
   end
endmodule

// File: rtl/sn_sort_pipe.sv
module sn_sort_pipe #(
   parameter int LANES = 4,
   parameter int KEY_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [LANES*KEY_W-1:0] in_data,
   output logic                   out_valid,
   output logic [LANES*KEY_W-1:0] out_data
);
   localparam int STAGES = sn_pkg::stage_count(LANES);
   localparam int BUS_W  = LANES * KEY_W;

   if ((LANES != 4) && (LANES != 8)) begin : g_bad_lanes
      $error("sn_sort_pipe: LANES must be 4 or 8, got %0d", LANES);
   end
   if (KEY_W < 1) begin : g_bad_width
      $error("sn_sort_pipe: KEY_W must be at least 1");
   end

   logic [STAGES:0] v_chain;
   logic [BUS_W-1:0] d_chain [STAGES+1];

   assign v_chain[0] = in_valid;
   assign d_chain[0] = in_data;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      sn_stage #(.LANES(LANES), .KEY_W(KEY_W), .STG(s)) u_stg (
         .clk   (clk),
         .rst_n (rst_n),
         .v_i   (v_chain[s]),
         .d_i   (d_chain[s]),
         .v_o   (v_chain[s+1]),
         .d_o   (d_chain[s+1])
      );
   end

   assign out_valid = v_chain[STAGES];
   assign out_data  = d_chain[STAGES];
endmodule

// File: rtl/sn_sort_pipe_chk.sv
module sn_sort_pipe_chk #(
   parameter int LANES = 4,
   parameter int KEY_W = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [LANES*KEY_W-1:0] in_data,
   input logic                   out_valid,
   input logic [LANES*KEY_W-1:0] out_data
);
   localparam int STAGES = sn_pkg::stage_count(LANES);
   localparam int SUM_W  = KEY_W + $clog2(LANES) + 1;

   function automatic logic [SUM_W-1:0] lane_sum(logic [LANES*KEY_W-1:0] v);
      logic [SUM_W-1:0] acc = '0;
      for (int i = 0; i < LANES; i++) acc += SUM_W'(v[i*KEY_W +: KEY_W]);
      return acc;
   endfunction

   function automatic logic is_ordered(logic [LANES*KEY_W-1:0] v);
      logic ok = 1'b1;
      for (int i = 1; i < LANES; i++)
         if (v[i*KEY_W +: KEY_W] < v[(i-1)*KEY_W +: KEY_W]) ok = 1'b0;
      return ok;
   endfunction

   logic [STAGES-1:0] vpipe;
   logic [SUM_W-1:0]  spipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpipe <= '0;
         for (int i = 0; i < STAGES; i++) spipe[i] <= '0;
      end else begin
         vpipe    <= {vpipe[STAGES-2:0], in_valid};
         spipe[0] <= lane_sum(in_data);
         for (int i = 1; i < STAGES; i++) spipe[i] <= spipe[i-1];
      end
   end

   // R1
   a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> is_ordered(out_data));

   // R2
   a_r2_sum_kept: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (lane_sum(out_data) == spipe[STAGES-1]));

   // R3, R6
   a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vpipe[STAGES-1]);

   // R5
   a_r5_reset_clears: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
endmodule

bind sn_sort_pipe sn_sort_pipe_chk #(.LANES(LANES), .KEY_W(KEY_W)) u_chk (.*);

// File: tb/sim_sn_sort_pipe.sv
`timescale 1ns/1ps
module sim_sn_sort_pipe;
   localparam int KW = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;
   logic rst_n = 1'b0;

   logic            v4 = 1'b0;
   logic [4*KW-1:0] d4 = '0;
   logic            o4v;
   logic [4*KW-1:0] o4d;
   logic            v8 = 1'b0;
   logic [8*KW-1:0] d8 = '0;
   logic            o8v;
   logic [8*KW-1:0] o8d;

   sn_sort_pipe #(.LANES(4), .KEY_W(KW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(v4), .in_data(d4),
      .out_valid(o4v), .out_data(o4d));
   sn_sort_pipe #(.LANES(8), .KEY_W(KW)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_data(d8),
      .out_valid(o8v), .out_data(o8d));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int fails  = 0;
   logic [31:0] rng = 32'h1234_5678;

   typedef struct { logic [127:0] d; int t; } item_t;
   item_t q4[$];
   item_t q8[$];

   function automatic logic [127:0] ref_sort(int n, logic [127:0] v);
      logic [KW-1:0] a [8];
      logic [KW-1:0] tmp;
      logic [127:0]  r = '0;
      for (int i = 0; i < n; i++) a[i] = v[i*KW +: KW];
      for (int i = 1; i < n; i++)
         for (int j = i; j > 0; j--)
            if (a[j] < a[j-1]) begin tmp = a[j]; a[j] = a[j-1]; a[j-1] = tmp; end
      for (int i = 0; i < n; i++) r[i*KW +: KW] = a[i];
      return r;
   endfunction

   function automatic string tag_of(int n, logic [127:0] v);
      bit dup = 0, hi = 0, lo = 0;
      for (int i = 0; i < n; i++) begin
         for (int j = i + 1; j < n; j++)
            if (v[i*KW +: KW] == v[j*KW +: KW]) dup = 1;
         if (v[i*KW + KW - 1]) hi = 1; else lo = 1;
      end
      if (n == 8) return "R9";
      if (dup) return "R7";
      if (hi && lo) return "R8";
      return "R2";
   endfunction

   function automatic bit ordered(int n, logic [127:0] v);
      for (int i = 1; i < n; i++)
         if (v[i*KW +: KW] < v[(i-1)*KW +: KW]) return 0;
      return 1;
   endfunction

   task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Scoreboard for the four-lane build (latency 3).
   always @(negedge clk) begin : mon4
      item_t it;
      if (rst_n) begin
         if ((q4.size() > 0) && (q4[0].t + 3 == cyc)) begin
            it = q4.pop_front();
            chk(o4v, "R3/R4 latency", 128'(o4v), 128'd1);
            if (o4v) begin
               chk(ordered(4, 128'(o4d)), "R1 order", 128'(o4d), ref_sort(4, it.d));
               chk(128'(o4d) == ref_sort(4, it.d), tag_of(4, it.d), 128'(o4d), ref_sort(4, it.d));
            end
         end else begin
            chk(!o4v, "R6 bubble", 128'(o4v), 128'd0);
         end
      end
   end

   // Scoreboard for the eight-lane build (latency 8).
   always @(negedge clk) begin : mon8
      item_t it;
      if (rst_n) begin
         if ((q8.size() > 0) && (q8[0].t + 8 == cyc)) begin
            it = q8.pop_front();
            chk(o8v, "R3/R4 latency", 128'(o8v), 128'd1);
            if (o8v) begin
               chk(ordered(8, o8d), "R1 order", o8d, ref_sort(8, it.d));
               chk(o8d == ref_sort(8, it.d), tag_of(8, it.d), o8d, ref_sort(8, it.d));
            end
         end else begin
            chk(!o8v, "R6 bubble", 128'(o8v), 128'd0);
         end
      end
   end

   task automatic send4(bit v, logic [4*KW-1:0] d);
      @(negedge clk);
      v4 = v; d4 = d;
      if (v) q4.push_back('{128'(d), cyc});
   endtask

   task automatic send8(bit v, logic [8*KW-1:0] d);
      @(negedge clk);
      v8 = v; d8 = d;
      if (v) q8.push_back('{d, cyc});
   endtask

   task automatic mid_reset();
      @(negedge clk);
      rst_n = 0; v4 = 0; v8 = 0;
      q4.delete(); q8.delete();
      repeat (2) begin
         @(negedge clk);
         chk(!o4v && !o8v, "R5 reset", 128'({o4v, o8v}), 128'd0);
      end
      rst_n = 1;
   endtask

   function automatic logic [31:0] step(logic [31:0] x);
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      return x;
   endfunction

   initial begin : watchdog
      #(4 * 150000);
      fails++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [KW-1:0] vals [5];
      logic [8*KW-1:0] w;
      int n = 0;
      vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0007;
      vals[3] = 16'h8000; vals[4] = 16'hFFFF;

      repeat (3) @(negedge clk);
      chk(!o4v && !o8v, "R5 reset", 128'({o4v, o8v}), 128'd0);
      rst_n = 1;

      // Four lanes: every tuple over five keys, with garbage bubbles.
      for (int a = 0; a < 5; a++)
         for (int b = 0; b < 5; b++)
            for (int c = 0; c < 5; c++)
               for (int e = 0; e < 5; e++) begin
                  send4(1, {vals[e], vals[c], vals[b], vals[a]});
                  n++;
                  if ((n % 7) == 0) begin
                     rng = step(rng);
                     send4(0, {rng, ~rng});
                  end
               end
      send4(0, '0);
      repeat (6) @(negedge clk);

      // Reset with a full pipeline: nothing stale may come out.
      for (int k = 0; k < 3; k++) send4(1, {16'd9, 16'd3, 16'd5, 16'd1});
      mid_reset();
      repeat (10) @(negedge clk);

      // Eight lanes: all min/max patterns.
      for (int p = 0; p < 256; p++) begin
         for (int i = 0; i < 8; i++) w[i*KW +: KW] = p[i] ? 16'hFFFF : 16'h0000;
         send8(1, w);
      end
      // Eight lanes: pseudo-random tuples and bubbles.
      for (int k = 0; k < 300; k++) begin
         for (int i = 0; i < 8; i++) begin
            rng = step(rng);
            w[i*KW +: KW] = rng[KW-1:0];
         end
         send8((k % 11) != 5, w);
      end
      send8(0, '0);
      repeat (12) @(negedge clk);

      chk((q4.size() == 0) && (q8.size() == 0), "R3 drain",
          128'(q4.size() + q8.size()), 128'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule